// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single line. The line is sampled once per pulse of an oversampling tick that runs at sixteen times the bit rate. A low level seen while idle is confirmed as a start bit by sampling again in the middle of the bit. After that, every bit of the frame is sampled at its own midpoint and shifted into a receive shift register. A frame carries eight data bits sent least significant bit first, then an address-marker bit, then a stop bit.

An address filter can be switched on. While it is on, frames whose marker bit is 0 are discarded without leaving any trace. The first frame whose marker bit is 1 passes the filter and switches the filter off in hardware, so the frames that follow it are received normally. This lets a node on a shared line ignore traffic addressed to others until an address frame arrives.

Accepted frames land in a data register and set a data-full flag. A bad stop bit sets a framing-error flag. A frame that completes while data-full is still set raises an overrun flag. Single-cycle acknowledge inputs clear the flags.

Top module: `mprx_receiver`

## Requirements
- R1: Reception begins only while `rxEnable` is 1, after a low line level is seen on a tick and is still low 8 ticks later. A low pulse shorter than that is ignored and leaves every output unchanged.
- R2: A frame is a 0 start bit, then 8 data bits least significant first, then the marker bit, then the stop bit, each bit lasting 16 ticks and sampled at its middle. With the filter off, a frame received while `dataFull` is 0 loads `rxData`, sets `dataFull` and copies its marker bit to `mpBit`.
- R3: An accepted frame whose stop bit is sampled as 0 sets `framingErr`, and its data is still loaded.
- R4: An accepted frame that completes while `dataFull` is 1 sets `overrunErr`, updates `mpBit`, and leaves `rxData` holding its old value.
- R5: A one-cycle `readAck` pulse clears `dataFull`. A one-cycle `errAck` pulse clears `framingErr` and `overrunErr`. Neither pulse touches the other flags.
- R6: Driving `rxEnable` to 0 abandons any frame in progress and leaves `dataFull`, `framingErr`, `overrunErr` and `rxData` unchanged. Reception works normally again once `rxEnable` returns to 1.
- R7: While `filterEn` is 1, a frame with marker bit 0 changes nothing. `rxData`, `dataFull`, `framingErr`, `overrunErr`, `mpBit` and `filterEn` all keep their values, even when the stop bit is 0 or `dataFull` is already 1.
- R8: While `filterEn` is 1, a frame with marker bit 1 sets `mpBit` to 1, clears `filterEn` to 0, and is otherwise handled as in R2 to R4.
- R9: After the filter has been cleared, frames with marker bit 0 are accepted again and set `mpBit` to 0.
- R10: A one-cycle `filterWrite` pulse loads `filterValue` into `filterEn`.
- R11: After reset, `rxData` is 0 and `dataFull`, `framingErr`, `overrunErr`, `mpBit` and `filterEn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| sampleTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxEnable | input | 1 | Receive enable |
| filterWrite | input | 1 | Pulse that loads `filterValue` into the filter enable |
| filterValue | input | 1 | Value written to the filter enable |
| readAck | input | 1 | Pulse that clears `dataFull` |
| errAck | input | 1 | Pulse that clears `framingErr` and `overrunErr` |
| rxData | output | 8 | Last accepted data byte |
| mpBit | output | 1 | Marker bit of the last accepted frame |
| dataFull | output | 1 | An unread byte is held in `rxData` |
| framingErr | output | 1 | An accepted frame had a 0 stop bit |
| overrunErr | output | 1 | A frame completed while `dataFull` was set |
| filterEn | output | 1 | Address filter active |

## Verification
A bit counter or sample phase that is off by one would put the wrong byte in `rxData` or flag a false framing error. This shows up at the flag register in the cycle after the stop-bit sample, so every frame check is made a few ticks after the stop bit. A filter enable that does not clear, or clears too early, shows up on `filterEn` within one frame. The frames after it then also land wrongly in `dataFull` and `overrunErr`, which is why the vector table chains frames that depend on the state left by the previous one. A control state that fails to return to idle after an abort or a glitch shows up as the next valid frame failing to load.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic sampleBit;  // capture the synchronised line into the shift register
    logic frameEnd;   // this capture is the stop bit: resolve the frame
  } rxStrobe_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_SHIFT = 2'd2
  } rxState_e;

endpackage

// File: rtl/mprx_ctrl.sv
module mprx_ctrl
  import mprx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FRAME_BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       sampleTick,
  input  logic       lineSync,
  output rxStrobe_t  strobe
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);

  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;

  logic midBit;
  assign midBit = (state == RX_SHIFT) && rxEnable && sampleTick && (tickCnt == FULL_LAST);

  always_comb begin
    strobe.sampleBit = midBit;
    strobe.frameEnd  = midBit && (bitIdx == IDX_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (sampleTick) begin
      unique case (state)
        RX_IDLE: begin
          if (!lineSync) begin
            state   <= RX_START;
            tickCnt <= '0;
          end
        end
        RX_START: begin
          if (tickCnt == HALF_LAST) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= lineSync ? RX_IDLE : RX_SHIFT;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_SHIFT: begin
          if (tickCnt == FULL_LAST) begin
            tickCnt <= '0;
            if (bitIdx == IDX_LAST) begin
              state  <= RX_IDLE;
              bitIdx <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R6
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == RX_IDLE));

  // R2
  bit_index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_SHIFT) |-> (bitIdx <= IDX_LAST));

  // R1
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_IDLE && !rxEnable) |=> (state == RX_IDLE));

endmodule

// File: rtl/mprx_datapath.sv
module mprx_datapath
  import mprx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobe_t            strobe,
  input  logic                 readAck,
  input  logic                 errAck,
  input  logic                 filterWrite,
  input  logic                 filterValue,
  output logic                 lineSync,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 mpBit,
  output logic                 dataFull,
  output logic                 framingErr,
  output logic                 overrunErr,
  output logic                 filterEn
);

  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int MP_POS     = DATA_BITS;
  localparam int STOP_POS   = DATA_BITS + 1;

  // Input synchroniser, reset to the idle (high) level
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
      end
    end
  endgenerate
  assign lineSync = syncQ[SYNC_STAGES-1];

  logic [FRAME_BITS-1:0] shReg;
  logic [FRAME_BITS-1:0] nextFrame;
  logic [DATA_BITS-1:0]  newData;
  logic                  newMp;
  logic                  newStop;
  logic                  dropFrame;

  assign nextFrame = {lineSync, shReg[FRAME_BITS-1:1]};
  assign newData   = nextFrame[DATA_BITS-1:0];
  assign newMp     = nextFrame[MP_POS];
  assign newStop   = nextFrame[STOP_POS];
  assign dropFrame = filterEn && !newMp;

  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '0;
    else if (strobe.sampleBit) shReg <= nextFrame;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData     <= '0;
      mpBit      <= 1'b0;
      dataFull   <= 1'b0;
      framingErr <= 1'b0;
      overrunErr <= 1'b0;
      filterEn   <= 1'b0;
    end else begin
      if (readAck) dataFull <= 1'b0;
      if (errAck) begin
        framingErr <= 1'b0;
        overrunErr <= 1'b0;
      end
      if (filterWrite) filterEn <= filterValue;
      if (strobe.frameEnd && !dropFrame) begin
        mpBit <= newMp;
        if (filterEn) filterEn <= 1'b0;
        if (dataFull) begin
          overrunErr <= 1'b1;
        end else begin
          rxData   <= newData;
          dataFull <= 1'b1;
        end
        if (!newStop) framingErr <= 1'b1;
      end
    end
  end

  // R4
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataFull |=> $stable(rxData));

  // R7
  filter_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEnd && filterEn && !newMp && !readAck && !errAck && !filterWrite)
    |=> ($stable(dataFull) && $stable(framingErr) && $stable(overrunErr) &&
         $stable(rxData) && $stable(mpBit) && filterEn));

  // R8
  filter_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEnd && filterEn && newMp) |=> (!filterEn && mpBit));

  // R3
  framing_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEnd && !filterEn && !newStop) |=> framingErr);

endmodule

// File: rtl/mprx_receiver.sv
module mprx_receiver
  import mprx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 sampleTick,
  input  logic                 rxEnable,
  input  logic                 filterWrite,
  input  logic                 filterValue,
  input  logic                 readAck,
  input  logic                 errAck,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 mpBit,
  output logic                 dataFull,
  output logic                 framingErr,
  output logic                 overrunErr,
  output logic                 filterEn
);

  localparam int FRAME_BITS = DATA_BITS + 2;

  rxStrobe_t strobe;
  logic      lineSync;

  mprx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rxEnable  (rxEnable),
    .sampleTick(sampleTick),
    .lineSync  (lineSync),
    .strobe    (strobe)
  );

  mprx_datapath #(
    .DATA_BITS  (DATA_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .strobe     (strobe),
    .readAck    (readAck),
    .errAck     (errAck),
    .filterWrite(filterWrite),
    .filterValue(filterValue),
    .lineSync   (lineSync),
    .rxData     (rxData),
    .mpBit      (mpBit),
    .dataFull   (dataFull),
    .framingErr (framingErr),
    .overrunErr (overrunErr),
    .filterEn   (filterEn)
  );

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !readAck && !errAck)
    |=> ($stable(dataFull) && $stable(framingErr) && $stable(overrunErr) && $stable(rxData)));

endmodule

// File: tb/mprx_receiver_tb.sv
module mprx_receiver_tb;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       sampleTick = 1'b0;
  logic       rxEnable = 1'b0;
  logic       filterWrite = 1'b0;
  logic       filterValue = 1'b0;
  logic       readAck = 1'b0;
  logic       errAck = 1'b0;
  logic [7:0] rxData;
  logic       mpBit, dataFull, framingErr, overrunErr, filterEn;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mprx_receiver u_dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .rxEnable(rxEnable), .filterWrite(filterWrite), .filterValue(filterValue),
    .readAck(readAck), .errAck(errAck), .rxData(rxData), .mpBit(mpBit),
    .dataFull(dataFull), .framingErr(framingErr), .overrunErr(overrunErr),
    .filterEn(filterEn)
  );

  // Oversampling tick, one pulse every TICK_DIV clocks
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % TICK_DIV;
      sampleTick = (phase == 0);
    end
  end

  // Vector fields: ack, setFilter, data[8], mp, stop | expData[8], full, fer, ovr, mp, filt
  localparam int NV = 9;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'hA5, 1'b0, 1'b1,  8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 plain frame
    {1'b0, 1'b0, 8'h3C, 1'b1, 1'b1,  8'hA5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 overrun
    {1'b1, 1'b0, 8'h0F, 1'b0, 1'b0,  8'h0F, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 bad stop
    {1'b1, 1'b1, 8'h55, 1'b0, 1'b1,  8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 dropped
    {1'b0, 1'b0, 8'h66, 1'b0, 1'b0,  8'h0F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 dropped, bad stop
    {1'b0, 1'b0, 8'h81, 1'b1, 1'b1,  8'h81, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 address frame
    {1'b1, 1'b0, 8'h7E, 1'b0, 1'b1,  8'h7E, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 normal again
    {1'b0, 1'b1, 8'h99, 1'b0, 1'b1,  8'h7E, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 dropped while full
    {1'b0, 1'b0, 8'hC3, 1'b1, 1'b1,  8'h7E, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}  // R8 with R4 overrun
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseAck(input logic rd, input logic er);
    @(negedge clk);
    readAck = rd;
    errAck = er;
    @(negedge clk);
    readAck = 1'b0;
    errAck = 1'b0;
  endtask

  task automatic writeFilter(input logic v);
    @(negedge clk);
    filterWrite = 1'b1;
    filterValue = v;
    @(negedge clk);
    filterWrite = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    rxLine = b;
    waitClks(BIT_CLKS);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic mp, input logic stop);
    @(negedge clk);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit(mp);
    sendBit(stop);
    rxLine = 1'b1;
    waitClks(8 * TICK_DIV);
  endtask

  function automatic logic [12:0] observed();
    return {rxData, dataFull, framingErr, overrunErr, mpBit, filterEn};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    waitClks(5);
    // R11 reset state
    check("R11 reset outputs", 32'(observed()), 32'h0);
    rstN = 1'b1;
    rxEnable = 1'b1;
    waitClks(20);
    check("R11 after release", 32'(observed()), 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) pulseAck(1'b1, 1'b1);
      if (VEC[v][23]) writeFilter(1'b1);
      sendFrame(VEC[v][22:15], VEC[v][14], VEC[v][13]);
      check($sformatf("R2/R3/R4/R7/R8/R9 vector %0d", v), 32'(observed()), 32'(VEC[v][12:0]));
    end

    // R5 separate acknowledges
    pulseAck(1'b0, 1'b1);
    check("R5 errAck clears overrun only", 32'(observed()), 32'({8'h7E, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}));
    pulseAck(1'b1, 1'b0);
    check("R5 readAck clears full", 32'(dataFull), 32'h0);

    // R1 disabled receiver ignores a frame
    rxEnable = 1'b0;
    sendFrame(8'h12, 1'b0, 1'b1);
    check("R1 disabled frame ignored", 32'(observed()), 32'({8'h7E, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}));
    rxEnable = 1'b1;
    waitClks(40);
    // R1 short low glitch is not a start bit
    rxLine = 1'b0;
    waitClks(3 * TICK_DIV);
    rxLine = 1'b1;
    waitClks(40 * TICK_DIV);
    check("R1 glitch ignored", 32'(observed()), 32'({8'h7E, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}));
    sendFrame(8'h34, 1'b0, 1'b1);
    check("R1 frame after glitch", 32'(observed()), 32'({8'h34, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}));

    // R6 abort mid-frame keeps flags
    @(negedge clk);
    sendBit(1'b0);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    rxEnable = 1'b0;
    rxLine = 1'b1;
    waitClks(200);
    check("R6 abort keeps flags", 32'(observed()), 32'({8'h34, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}));
    rxEnable = 1'b1;
    waitClks(100);
    pulseAck(1'b1, 1'b0);
    sendFrame(8'h5A, 1'b0, 1'b1);
    check("R6 recovery after abort", 32'(observed()), 32'({8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}));

    // R10 software write of filter enable
    writeFilter(1'b1);
    check("R10 filter set", 32'(filterEn), 32'h1);
    writeFilter(1'b0);
    check("R10 filter cleared", 32'(filterEn), 32'h0);

    finish_run();
  end

endmodule